// File: doc/BRIEF.md
# Truncated-Modulus Up/Down Counter

A synchronous counter with a `WIDTH`-bit state whose modulus is set by a parameter, anywhere from 2 to 2^`WIDTH` (2 to 16 with the defaults). A direction input chooses incrementing or decrementing. A count enable gates every change of state. In both directions the count stays inside 0 .. MODULUS-1 and wraps at the ends.

Recycling while counting up does not use a full compare against the top value. It decodes only those bit positions that are 1 in the modulus value, applied to the incremented count. This has the same sparse structure as a gate-based clear, but the result is a synchronous load of zero, so the out-of-range value never reaches the register.

A combinational carry/borrow output marks the cycle in which the next enabled edge will wrap, so that it can drive the enable of a following stage. A registered terminal strobe marks the cycle just after a wrap has taken place.

Top module: `modn_updown_counter`

## Requirements
- R1: While `rst` is 1 at a rising edge, `count` becomes 0 and `term_strobe` becomes 0, whatever `en` and `up` are (reset wins over enable).
- R2: With `en`=1 and `up`=1 and `count` below MODULUS-1, `count` increases by exactly 1 at the next edge.
- R3: With `en`=1 and `up`=1 and `count` equal to MODULUS-1, `count` becomes 0 at the next edge. `count` never shows a value of MODULUS or above (for MODULUS 6 the value 6 never appears; for MODULUS 16 the natural 15-to-0 rollover applies).
- R4: With `en`=1 and `up`=0 and `count` above 0, `count` decreases by exactly 1 at the next edge.
- R5: With `en`=1 and `up`=0 and `count` equal to 0, `count` becomes MODULUS-1 at the next edge.
- R6: With `en`=0 and no reset, `count` holds its value, and `carry_out` is 0.
- R7: `carry_out` is 1 in the same cycle exactly when `en`=1 and `count` is at the boundary for the present direction: MODULUS-1 when `up`=1, 0 when `up`=0.
- R8: `term_strobe` is 1 for exactly the one cycle that follows an edge at which an enabled wrap occurred (in either direction), and is 0 otherwise.
- R9: Changing `up` in the middle of a sequence takes effect at the very next enabled edge, with no lost or extra step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| count | output | WIDTH | Registered count value |
| carry_out | output | 1 | Carry (up) or borrow (down): the next enabled edge wraps |
| term_strobe | output | 1 | Registered one-cycle pulse after a wrap |

## Verification
The bench runs three instances side by side with moduli 6, 10 and 16. Each one goes through two whole laps upward and two downward. A decoder that picked the wrong bits would either recycle early at a lower value or let the out-of-range state appear; for modulus 6, for example, a 6 would show up. Turning around from up to down in the middle of a sequence, and also right at zero, exposes a direction mux that acts late or wraps to the wrong end. Reset asserted together with enable, and pauses with enable low, catch a reset that loses to the count path and a carry that is not gated by enable.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  // Width needed to hold the modulus value itself (one bit wider than the count)
  function automatic int mod_bits(input int width);
    return width + 1;
  endfunction

endpackage

// File: rtl/ucnt_sparse_dec.sv
// Detects that every bit set in PATTERN is also set in value.
// Bits that are zero in PATTERN are don't-care.
module ucnt_sparse_dec #(
  parameter int              W       = 5,
  parameter logic [W-1:0]    PATTERN = '1
) (
  input  logic [W-1:0] value,
  output logic         hit
);

  logic [W-1:0] term;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (PATTERN[i]) begin : g_used
      assign term[i] = value[i];
    end else begin : g_skip
      assign term[i] = 1'b1;
    end
  end

  assign hit = &term;

endmodule

// File: rtl/ucnt_step.sv
// Next-state and boundary logic for the counter.
module ucnt_step
  import ucnt_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             en,
  input  logic             up,
  output logic [WIDTH-1:0] nxt,
  output logic             boundary,
  output logic             wrap
);

  localparam int               XW      = mod_bits(WIDTH);
  localparam logic [XW-1:0]    MOD_VAL = XW'(MODULUS);
  localparam logic [WIDTH-1:0] TOP     = WIDTH'(MODULUS - 1);

  dir_e            dir;
  logic [XW-1:0]   inc;
  logic [WIDTH-1:0] dec;
  logic            up_hit;
  logic            dn_zero;

  assign dir     = dir_e'(up);
  assign inc     = {1'b0, cur} + 1'b1;
  assign dec     = cur - 1'b1;
  assign dn_zero = (cur == '0);

  // Recycle decode uses only the one-bits of the modulus value
  ucnt_sparse_dec #(
    .W       (XW),
    .PATTERN (MOD_VAL)
  ) u_recycle (
    .value (inc),
    .hit   (up_hit)
  );

  always_comb begin
    boundary = (dir == DIR_UP) ? up_hit : dn_zero;
    wrap     = en & boundary;
    nxt      = cur;
    if (en) begin
      if (dir == DIR_UP) begin
        nxt = up_hit ? '0 : inc[WIDTH-1:0];
      end else begin
        nxt = dn_zero ? TOP : dec;
      end
    end
  end

endmodule

// File: rtl/modn_updown_counter.sv
module modn_updown_counter #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             up,
  output logic [WIDTH-1:0] count,
  output logic             carry_out,
  output logic             term_strobe
);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             at_edge;
  logic             wrap_now;
  logic             strobe_q;

  ucnt_step #(
    .WIDTH   (WIDTH),
    .MODULUS (MODULUS)
  ) u_step (
    .cur      (cnt_q),
    .en       (en),
    .up       (up),
    .nxt      (cnt_d),
    .boundary (at_edge),
    .wrap     (wrap_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      strobe_q <= wrap_now;
    end
  end

  assign count       = cnt_q;
  assign carry_out   = wrap_now;
  assign term_strobe = strobe_q;

endmodule

// File: rtl/modn_updown_counter_chk.sv
module modn_updown_counter_chk #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             up,
  input logic [WIDTH-1:0] count,
  input logic             carry_out,
  input logic             term_strobe
);

  localparam logic [WIDTH-1:0] TOP = WIDTH'(MODULUS - 1);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (count == '0) && !term_strobe); // R1

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && up && count != TOP) |=> count == $past(count) + 1'b1); // R2

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (en && up && count == TOP) |=> count == '0); // R3

  AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    count <= TOP); // R3

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && !up && count != '0) |=> count == $past(count) - 1'b1); // R4

  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
    (en && !up && count == '0) |=> count == TOP); // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count)); // R6

  AST_CARRY_GATED: assert property (@(posedge clk) disable iff (rst)
    carry_out |-> en && (up ? count == TOP : count == '0)); // R7

  AST_STROBE_AFTER_WRAP: assert property (@(posedge clk) disable iff (rst)
    carry_out |=> term_strobe); // R8

  AST_STROBE_ONLY_AFTER_WRAP: assert property (@(posedge clk) disable iff (rst)
    term_strobe |-> $past(carry_out)); // R8

endmodule

bind modn_updown_counter modn_updown_counter_chk #(
  .WIDTH   (WIDTH),
  .MODULUS (MODULUS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .up          (up),
  .count       (count),
  .carry_out   (carry_out),
  .term_strobe (term_strobe)
);

// File: tb/modn_updown_counter_test.sv
`timescale 1ns/1ps
module modn_updown_counter_test;

  localparam int W = 4;
  localparam int MODS [3] = '{10, 6, 16};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic up  = 1'b1;

  logic [W-1:0] q  [3];
  logic         co [3];
  logic         ts [3];

  int  m_cnt [3];
  bit  m_tc  [3];
  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  modn_updown_counter #(.WIDTH(W), .MODULUS(10)) uut (
    .clk(clk), .rst(rst), .en(en), .up(up),
    .count(q[0]), .carry_out(co[0]), .term_strobe(ts[0]));

  modn_updown_counter #(.WIDTH(W), .MODULUS(6)) uut_m6 (
    .clk(clk), .rst(rst), .en(en), .up(up),
    .count(q[1]), .carry_out(co[1]), .term_strobe(ts[1]));

  modn_updown_counter #(.WIDTH(W), .MODULUS(16)) uut_m16 (
    .clk(clk), .rst(rst), .en(en), .up(up),
    .count(q[2]), .carry_out(co[2]), .term_strobe(ts[2]));

  // Table entries: {rst, en, up, expected count of the modulus-10 instance}
  localparam int NV = 16;
  localparam logic [6:0] VEC [NV] = '{
    {3'b111, 4'd0}, {3'b011, 4'd1}, {3'b011, 4'd2}, {3'b001, 4'd2},
    {3'b010, 4'd1}, {3'b010, 4'd0}, {3'b010, 4'd9}, {3'b010, 4'd8},
    {3'b011, 4'd9}, {3'b011, 4'd0}, {3'b000, 4'd0}, {3'b010, 4'd9},
    {3'b011, 4'd0}, {3'b101, 4'd0}, {3'b011, 4'd1}, {3'b110, 4'd0}
  };

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Reference model built from the requirements
  task automatic model_edge(input bit r, input bit e, input bit u);
    for (int k = 0; k < 3; k++) begin
      int  top = MODS[k] - 1;
      bit  wr;
      if (r) begin
        m_cnt[k] = 0;
        m_tc[k]  = 1'b0;
      end else begin
        wr = e && (u ? (m_cnt[k] == top) : (m_cnt[k] == 0));
        if (e) begin
          if (u) m_cnt[k] = (m_cnt[k] == top) ? 0 : m_cnt[k] + 1;
          else   m_cnt[k] = (m_cnt[k] == 0) ? top : m_cnt[k] - 1;
        end
        m_tc[k] = wr;
      end
    end
  endtask

  // Called at a falling edge: drive, check carry, clock, check state
  task automatic step(input bit r, input bit e, input bit u, input string tag);
    rst = r; en = e; up = u;
    #1;
    for (int k = 0; k < 3; k++) begin
      int top = MODS[k] - 1;
      bit exp_co = e && (u ? (m_cnt[k] == top) : (m_cnt[k] == 0));
      check(e ? "R7" : "R6", $sformatf("carry_out mod%0d", MODS[k]), int'(co[k]), int'(exp_co));
    end
    @(posedge clk);
    model_edge(r, e, u);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check(tag, $sformatf("count mod%0d", MODS[k]), int'(q[k]), m_cnt[k]);
      check(r ? "R1" : "R8", $sformatf("term_strobe mod%0d", MODS[k]), int'(ts[k]), int'(m_tc[k]));
    end
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) begin
      m_cnt[k] = 0;
      m_tc[k]  = 1'b0;
    end
    @(negedge clk);
    step(1'b1, 1'b0, 1'b1, "R1");
    step(1'b1, 1'b1, 1'b1, "R1");   // reset beats enable

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [6:0] v = VEC[i];
      step(v[6], v[5], v[4], "R9");
      check("R9", $sformatf("table row %0d count", i), int'(q[0]), int'(v[3:0]));
    end

    // Two full laps upward: R2 increments, R3 recycle without reaching MODULUS
    step(1'b1, 1'b0, 1'b1, "R1");
    for (int i = 0; i < 32; i++) begin
      step(1'b0, 1'b1, 1'b1, "R3");
      check("R3", "mod6 never shows 6", int'(q[1] >= 4'd6), 0);
      check("R2", "mod10 below 10", int'(q[0] >= 4'd10), 0);
    end

    // Two full laps downward: R4 decrement, R5 wrap from 0
    step(1'b1, 1'b0, 1'b0, "R1");
    for (int i = 0; i < 32; i++) step(1'b0, 1'b1, 1'b0, (i == 0) ? "R5" : "R4");

    // Enable low holds: R6
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, i[0], "R6");

    // Direction change mid-sequence: R9
    step(1'b1, 1'b0, 1'b1, "R1");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, "R2");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, "R9");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, "R9");

    // Reset in the middle of enabled counting: R1
    step(1'b1, 1'b1, 1'b0, "R1");
    check("R1", "mod10 count after reset", int'(q[0]), 0);
    check("R1", "mod16 strobe after reset", int'(ts[2]), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule